// File: doc/BRIEF.md
# Reset and Interrupt Pin Controller

This block owns one external input pin that serves two purposes. In its default mode the pin is an active-low reset: while it is low the block holds the internal power-up-clear request (`puc_o`) high, and once the pin returns high the request is released in step with the clock and the restart vector address is offered to the processor. Software can switch the pin into interrupt mode through a one-byte control register. In that mode a chosen edge (rising or falling) on the synchronised pin sets a pending flag, and an enabled flag raises a request towards the processor.

An interrupt event on the pin also fires a one-cycle power-up-clear pulse. That pulse clears the control register, so the pin falls back to reset mode, and a pin that is still low then keeps the processor in reset. Because the edge detector compares the pin level with a polarity-adjusted history, flipping the edge-select bit while in interrupt mode can itself create an event when the pin already sits at the new active level.

The processor acknowledges a request with `irq_ack`, which clears the flag and loads the interrupt vector address; software may also clear the flag directly.

Top module: `rnm_pin_ctrl`

## Requirements
- R1: The control register is written when `ctl_wr` is high and `ctl_addr` equals `CTL_ADDR` (default 0x3C). Bit 5 selects the pin role (0 = reset, 1 = interrupt) and bit 6 the active edge (0 = rising, 1 = falling). `ctl_rdata` returns these two bits in the same positions, with every other bit zero.
- R2: A write to any other address, or a write made while `puc_o` is high, leaves the control register unchanged.
- R3: While `puc_o` is high, both control bits are cleared at the next rising clock edge.
- R4: In reset mode a low pin drives `puc_o` high at once, without waiting for a clock. After the pin goes high, `puc_o` falls on the second rising edge. `vec_addr` reads 0xFFFE after any cycle in which `puc_o` was high.
- R5: In interrupt mode the selected edge of the pin sets `flag_q` on the third rising clock edge after the pin changes: two synchroniser stages, then the flag register.
- R6: `flag_q` stays set until `flag_clr` is high or an acknowledge is accepted, and a new event wins over a clear in the same cycle. `nmi_ie` gates only `irq_req` and never the setting of `flag_q`.
- R7: `irq_ack` while `irq_req` is high loads 0xFFFC into `vec_addr` and clears `flag_q`. `irq_ack` without a request has no effect.
- R8: An interrupt event raises `puc_o` for exactly one cycle, in the same cycle that `flag_q` rises. If the pin is still low after that pulse, `puc_o` stays high until the pin goes high again.
- R9: In interrupt mode, a write to the edge bit produces an event when the pin already sits at the new active level. In reset mode no change of the edge bit produces an event.
- R10: `por_n` low clears the control bits and the flag, sets `vec_addr` to 0xFFFE and holds `puc_o` high. After `por_n` goes high, `puc_o` falls on the second rising edge, provided the pin is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| pin_i | input | 1 | Raw external reset/interrupt pin |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_addr | input | ADDR_W | Write address |
| ctl_wdata | input | 8 | Write data |
| ctl_rdata | output | 8 | Control register read value |
| nmi_ie | input | 1 | Interrupt enable for the pin event |
| flag_clr | input | 1 | Software clear of the pending flag |
| irq_ack | input | 1 | Processor accepts the interrupt |
| flag_q | output | 1 | Pending flag |
| irq_req | output | 1 | Interrupt request to the processor |
| puc_o | output | 1 | Internal power-up-clear request |
| vec_addr | output | 16 | Vector word address for the next fetch |

## Verification
The assertions assume that `pin_i` may change at any time but holds one level for each clock period as seen at the sampling edge. They also assume that `irq_ack` and `flag_clr` are ordinary synchronous strobes. The bench keeps to these assumptions by changing every input, the pin included, only once per period, well away from the rising edge. Random pin toggles are kept infrequent, so reset-mode holds and interrupt edges both occur many times. Directed cases cover a polarity flip under a steady pin, a pin held low through the event pulse, and writes made during reset.

// File: rtl/rnm_pkg.sv
package rnm_pkg;

    localparam int RNM_VEC_W = 16;

    typedef struct packed {
        logic                 mode;      // 1 = interrupt role
        logic                 edge_sel;  // 1 = falling edge active
        logic                 act_prev;  // previous polarity-adjusted level
        logic                 flag;      // pending event
        logic                 evt_puc;   // one-cycle clear pulse from an event
        logic [RNM_VEC_W-1:0] vec;       // vector word address
    } rnm_state_t;

endpackage

// File: rtl/rnm_sync.sv
module rnm_sync #(
    parameter int   STG     = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STG-1:0] stage_q;

    generate
        for (genvar i = 0; i < STG; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[i] <= RST_VAL;
                end else if (i == 0) begin
                    stage_q[i] <= d;
                end else begin
                    stage_q[i] <= stage_q[(i == 0) ? 0 : i-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STG-1];
endmodule

// File: rtl/rnm_puc_rel.sv
module rnm_puc_rel #(
    parameter int STG = 2
) (
    input  logic clk,
    input  logic arst_n,   // assertion is immediate
    output logic rel_o     // 1 once release has crossed STG edges
);
    logic [STG-1:0] rel_q;

    generate
        for (genvar i = 0; i < STG; i++) begin : g_rel
            always_ff @(posedge clk or negedge arst_n) begin
                if (!arst_n) begin
                    rel_q[i] <= 1'b0;
                end else if (i == 0) begin
                    rel_q[i] <= 1'b1;
                end else begin
                    rel_q[i] <= rel_q[(i == 0) ? 0 : i-1];
                end
            end
        end
    endgenerate

    assign rel_o = rel_q[STG-1];
endmodule

// File: rtl/rnm_core.sv
module rnm_core
    import rnm_pkg::*;
#(
    parameter logic [RNM_VEC_W-1:0] VEC_RST = 16'hFFFE,
    parameter logic [RNM_VEC_W-1:0] VEC_NMI = 16'hFFFC
) (
    input  logic                 clk,
    input  logic                 por_n,
    input  logic                 sync_pin,
    input  logic                 puc,
    input  logic                 wr_hit,
    input  logic                 wr_mode,
    input  logic                 wr_edge,
    input  logic                 nmi_ie,
    input  logic                 flag_clr,
    input  logic                 irq_ack,
    output logic                 mode_o,
    output logic                 edge_o,
    output logic                 flag_o,
    output logic                 evt_puc_o,
    output logic                 irq_req_o,
    output logic [RNM_VEC_W-1:0] vec_o
);
    localparam rnm_state_t RST_STATE = '{
        mode:     1'b0,
        edge_sel: 1'b0,
        act_prev: 1'b1,   // idle pin is high, rising polarity
        flag:     1'b0,
        evt_puc:  1'b0,
        vec:      VEC_RST
    };

    rnm_state_t st_q, st_d;
    logic act_lvl, evt, accept, req;

    assign req = st_q.flag & nmi_ie;

    always_comb begin
        act_lvl = sync_pin ^ st_q.edge_sel;
        evt     = st_q.mode & act_lvl & ~st_q.act_prev;
        accept  = irq_ack & req;

        st_d          = st_q;
        st_d.act_prev = act_lvl;
        st_d.evt_puc  = evt;

        if (puc) begin
            st_d.mode     = 1'b0;
            st_d.edge_sel = 1'b0;
        end else if (wr_hit) begin
            st_d.mode     = wr_mode;
            st_d.edge_sel = wr_edge;
        end

        if (evt) begin
            st_d.flag = 1'b1;
        end else if (flag_clr || accept) begin
            st_d.flag = 1'b0;
        end

        if (puc) begin
            st_d.vec = VEC_RST;
        end else if (accept) begin
            st_d.vec = VEC_NMI;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q <= RST_STATE;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o    = st_q.mode;
    assign edge_o    = st_q.edge_sel;
    assign flag_o    = st_q.flag;
    assign evt_puc_o = st_q.evt_puc;
    assign irq_req_o = req;
    assign vec_o     = st_q.vec;
endmodule

// File: rtl/rnm_pin_ctrl.sv
module rnm_pin_ctrl
    import rnm_pkg::*;
#(
    parameter int                   ADDR_W   = 8,
    parameter logic [ADDR_W-1:0]    CTL_ADDR = 8'h3C,
    parameter int                   SYNC_STG = 2,
    parameter int                   REL_STG  = 2,
    parameter int                   MODE_BIT = 5,
    parameter int                   EDGE_BIT = 6,
    parameter logic [RNM_VEC_W-1:0] VEC_RST  = 16'hFFFE,
    parameter logic [RNM_VEC_W-1:0] VEC_NMI  = 16'hFFFC
) (
    input  logic                 clk,
    input  logic                 por_n,
    input  logic                 pin_i,
    input  logic                 ctl_wr,
    input  logic [ADDR_W-1:0]    ctl_addr,
    input  logic [7:0]           ctl_wdata,
    output logic [7:0]           ctl_rdata,
    input  logic                 nmi_ie,
    input  logic                 flag_clr,
    input  logic                 irq_ack,
    output logic                 flag_q,
    output logic                 irq_req,
    output logic                 puc_o,
    output logic [RNM_VEC_W-1:0] vec_addr
);
    logic sync_pin, mode, edge_sel, evt_puc, rel, arst_n, wr_hit;

    rnm_sync #(.STG(SYNC_STG), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (por_n),
        .d     (pin_i),
        .q     (sync_pin)
    );

    // In reset role a low pin resets the release chain immediately.
    assign arst_n = por_n & (pin_i | mode);

    rnm_puc_rel #(.STG(REL_STG)) u_rel (
        .clk    (clk),
        .arst_n (arst_n),
        .rel_o  (rel)
    );

    assign puc_o  = ~rel | evt_puc;
    assign wr_hit = ctl_wr & (ctl_addr == CTL_ADDR);

    rnm_core #(.VEC_RST(VEC_RST), .VEC_NMI(VEC_NMI)) u_core (
        .clk       (clk),
        .por_n     (por_n),
        .sync_pin  (sync_pin),
        .puc       (puc_o),
        .wr_hit    (wr_hit),
        .wr_mode   (ctl_wdata[MODE_BIT]),
        .wr_edge   (ctl_wdata[EDGE_BIT]),
        .nmi_ie    (nmi_ie),
        .flag_clr  (flag_clr),
        .irq_ack   (irq_ack),
        .mode_o    (mode),
        .edge_o    (edge_sel),
        .flag_o    (flag_q),
        .evt_puc_o (evt_puc),
        .irq_req_o (irq_req),
        .vec_o     (vec_addr)
    );

    always_comb begin
        ctl_rdata           = '0;
        ctl_rdata[MODE_BIT] = mode;
        ctl_rdata[EDGE_BIT] = edge_sel;
    end
endmodule

// File: rtl/rnm_chk.sv
module rnm_chk #(
    parameter logic [15:0] VEC_RST = 16'hFFFE,
    parameter logic [15:0] VEC_NMI = 16'hFFFC
) (
    input logic        clk,
    input logic        por_n,
    input logic        pin_i,
    input logic        flag_clr,
    input logic        irq_ack,
    input logic        irq_req,
    input logic        flag_q,
    input logic        puc_o,
    input logic [7:0]  ctl_rdata,
    input logic [15:0] vec_addr
);
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!por_n)
        (flag_q && !flag_clr && !(irq_ack && irq_req)) |=> flag_q);          // R6

    AST_PUC_PIN_LOW: assert property (@(posedge clk) disable iff (!por_n)
        (!ctl_rdata[5] && !pin_i) |-> puc_o);                              // R4

    AST_PUC_CLR_CTL: assert property (@(posedge clk) disable iff (!por_n)
        puc_o |=> (ctl_rdata[6:5] == 2'b00));                              // R3

    AST_PUC_VEC: assert property (@(posedge clk) disable iff (!por_n)
        puc_o |=> (vec_addr == VEC_RST));                                  // R4

    AST_ACK_VEC: assert property (@(posedge clk) disable iff (!por_n)
        (irq_ack && irq_req && !puc_o) |=> (vec_addr == VEC_NMI));         // R7

    AST_EVT_PUC: assert property (@(posedge clk) disable iff (!por_n)
        $rose(flag_q) |-> puc_o);                                          // R8
endmodule

bind rnm_pin_ctrl rnm_chk #(.VEC_RST(VEC_RST), .VEC_NMI(VEC_NMI)) u_chk (
    .clk       (clk),
    .por_n     (por_n),
    .pin_i     (pin_i),
    .flag_clr  (flag_clr),
    .irq_ack   (irq_ack),
    .irq_req   (irq_req),
    .flag_q    (flag_q),
    .puc_o     (puc_o),
    .ctl_rdata (ctl_rdata),
    .vec_addr  (vec_addr)
);

// File: tb/sim_rnm_pin_ctrl.sv
`timescale 1ns/1ps
module sim_rnm_pin_ctrl;
    localparam logic [7:0] A_CTL = 8'h3C;

    logic        clk = 1'b0;
    logic        por_n = 1'b0, pin = 1'b1, wr = 1'b0, ie = 1'b0, clr = 1'b0, ack = 1'b0;
    logic [7:0]  addr = 8'h00, wdata = 8'h00;
    logic [7:0]  rdata;
    logic        flag, req, puc;
    logic [15:0] vec;

    int checks = 0, errors = 0;
    bit cmp_on = 1'b0, done = 1'b0;

    always #10 clk = ~clk;

    rnm_pin_ctrl u0 (
        .clk(clk), .por_n(por_n), .pin_i(pin), .ctl_wr(wr), .ctl_addr(addr),
        .ctl_wdata(wdata), .ctl_rdata(rdata), .nmi_ie(ie), .flag_clr(clr),
        .irq_ack(ack), .flag_q(flag), .irq_req(req), .puc_o(puc), .vec_addr(vec)
    );

    task automatic chk(input bit ok, input string rq, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", rq, act, exp, $time);
        end
    endtask

    // Reference model built from the requirements.
    logic        m_mode = 0, m_es = 0, m_prev = 1, m_flag = 0, m_np = 0;
    logic [1:0]  m_s = 2'b11, m_rel = 2'b00;
    logic [15:0] m_vec = 16'hFFFE;

    function automatic logic m_arst();
        return por_n & (pin | m_mode);
    endfunction
    function automatic logic m_puc();
        return !m_arst() | !m_rel[1] | m_np;
    endfunction

    always @(posedge clk) begin
        logic act, evt, p, acc, nmode, nes;
        if (!por_n) begin
            m_mode = 0; m_es = 0; m_prev = 1; m_flag = 0; m_np = 0;
            m_s = 2'b11; m_rel = 2'b00; m_vec = 16'hFFFE;
        end else begin
            act = m_s[1] ^ m_es;
            evt = m_mode & act & !m_prev;
            p   = m_puc();
            acc = ack & m_flag & ie;
            nmode = m_mode; nes = m_es;
            if (p) begin nmode = 0; nes = 0; end
            else if (wr && addr == A_CTL) begin nmode = wdata[5]; nes = wdata[6]; end
            if (evt) m_flag = 1; else if (clr || acc) m_flag = 0;
            if (p) m_vec = 16'hFFFE; else if (acc) m_vec = 16'hFFFC;
            m_prev = act;
            m_np   = evt;
            m_s    = {m_s[0], pin};
            m_rel  = m_arst() ? {m_rel[0], 1'b1} : 2'b00;
            m_mode = nmode; m_es = nes;
            if (!m_arst()) m_rel = 2'b00;
        end
    end

    always @(negedge clk) begin
        if (cmp_on && !done) begin
            chk(puc === m_puc(), "R4 puc_o", {15'd0, puc}, {15'd0, m_puc()});
            chk(flag === m_flag, "R5 flag_q", {15'd0, flag}, {15'd0, m_flag});
            chk(req === (m_flag & ie), "R6 irq_req", {15'd0, req}, {15'd0, m_flag & ie});
            chk(vec === m_vec, "R7 vec_addr", vec, m_vec);
            chk(rdata === {1'b0, m_es, m_mode, 5'b0}, "R1 ctl_rdata",
                {8'd0, rdata}, {8'd0, 1'b0, m_es, m_mode, 5'b0});
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
        #2;
    endtask

    task automatic wr_ctl(input logic [7:0] a, input logic [7:0] d);
        wr = 1; addr = a; wdata = d;
        cyc(1);
        wr = 0;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1D5E_0A77));
        cyc(2);
        cmp_on = 1;
        // R10: state during power-on reset
        chk(puc === 1'b1, "R10 puc during por", {15'd0, puc}, 16'd1);
        chk(flag === 1'b0, "R10 flag during por", {15'd0, flag}, 16'd0);
        chk(vec === 16'hFFFE, "R10 vec during por", vec, 16'hFFFE);
        chk(rdata === 8'h00, "R10 ctl during por", {8'd0, rdata}, 16'h0);
        por_n = 1;
        cyc(1);
        chk(puc === 1'b1, "R10 puc one edge after release", {15'd0, puc}, 16'd1);
        cyc(1);
        chk(puc === 1'b0, "R10 puc two edges after release", {15'd0, puc}, 16'd0);

        // R2 / R1: address decode and read-back
        wr_ctl(8'h3D, 8'h60);
        chk(rdata === 8'h00, "R2 foreign address", {8'd0, rdata}, 16'h0);
        wr_ctl(A_CTL, 8'hBF);
        chk(rdata === 8'h20, "R1 readback masks other bits", {8'd0, rdata}, 16'h20);

        // R5 / R8: rising edge event
        ie = 1;
        pin = 0; cyc(3);
        chk(flag === 1'b0, "R5 falling edge ignored with rising select", {15'd0, flag}, 16'd0);
        pin = 1; cyc(2);
        chk(flag === 1'b0, "R5 flag not before third edge", {15'd0, flag}, 16'd0);
        cyc(1);
        chk(flag === 1'b1, "R5 flag on third edge", {15'd0, flag}, 16'd1);
        chk(puc === 1'b1, "R8 event pulses puc", {15'd0, puc}, 16'd1);
        chk(req === 1'b1, "R6 request when enabled", {15'd0, req}, 16'd1);
        cyc(1);
        chk(puc === 1'b0, "R8 pulse lasts one cycle", {15'd0, puc}, 16'd0);
        chk(rdata === 8'h00, "R3 control cleared by puc", {8'd0, rdata}, 16'h0);
        chk(vec === 16'hFFFE, "R4 reset vector after puc", vec, 16'hFFFE);

        // R7: acknowledge
        ack = 1; cyc(1); ack = 0;
        chk(vec === 16'hFFFC, "R7 interrupt vector on ack", vec, 16'hFFFC);
        chk(flag === 1'b0, "R7 ack clears flag", {15'd0, flag}, 16'd0);

        // R9: polarity flip under steady high pin in interrupt role
        wr_ctl(A_CTL, 8'h20);
        wr_ctl(A_CTL, 8'h60);
        wr_ctl(A_CTL, 8'h20);
        cyc(1);
        chk(flag === 1'b1, "R9 polarity flip raises event", {15'd0, flag}, 16'd1);
        cyc(1);
        clr = 1; cyc(1); clr = 0;
        chk(flag === 1'b0, "R6 software clear", {15'd0, flag}, 16'd0);
        wr_ctl(A_CTL, 8'h40);
        wr_ctl(A_CTL, 8'h00);
        cyc(2);
        chk(flag === 1'b0, "R9 no event in reset role", {15'd0, flag}, 16'd0);

        // R6 / R7: masked flag and stray ack
        ie = 0;
        wr_ctl(A_CTL, 8'h20);
        pin = 0; cyc(3);
        pin = 1; cyc(3);
        chk(flag === 1'b1, "R6 flag sets while masked", {15'd0, flag}, 16'd1);
        chk(req === 1'b0, "R6 request masked", {15'd0, req}, 16'd0);
        cyc(1);
        ack = 1; cyc(1); ack = 0;
        chk(flag === 1'b1, "R7 ack without request ignored", {15'd0, flag}, 16'd1);
        chk(vec === 16'hFFFE, "R7 vec kept on stray ack", vec, 16'hFFFE);
        ie = 1; #1;
        chk(req === 1'b1, "R6 enable exposes pending flag", {15'd0, req}, 16'd1);
        clr = 1; cyc(1); clr = 0;

        // R8 / R2: falling event with pin held low
        wr_ctl(A_CTL, 8'h60);
        pin = 0; cyc(3);
        chk(flag === 1'b1, "R5 falling edge event", {15'd0, flag}, 16'd1);
        cyc(1);
        chk(puc === 1'b1, "R8 held low keeps puc", {15'd0, puc}, 16'd1);
        wr_ctl(A_CTL, 8'h20);
        chk(rdata === 8'h00, "R2 write during puc ignored", {8'd0, rdata}, 16'h0);
        cyc(4);
        chk(puc === 1'b1, "R8 still in reset", {15'd0, puc}, 16'd1);
        pin = 1; cyc(1);
        chk(puc === 1'b1, "R4 release after one edge pending", {15'd0, puc}, 16'd1);
        cyc(1);
        chk(puc === 1'b0, "R4 release on second edge", {15'd0, puc}, 16'd0);
        clr = 1; cyc(1); clr = 0;

        // Random phase, checked by the model each cycle
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(15) == 0) pin = ~pin;
            wr = ($urandom_range(7) == 0);
            addr = ($urandom_range(3) == 0) ? 8'($urandom) : A_CTL;
            wdata = 8'($urandom);
            clr = ($urandom_range(15) == 0);
            ack = ($urandom_range(3) == 0);
            if ($urandom_range(7) == 0) ie = ~ie;
            cyc(1);
        end
        wr = 0; clr = 0; ack = 0;
        cyc(1);

        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule